// File: doc/BRIEF.md
# Trap and Privilege-Mode Controller

This block keeps the execution mode of a small RISC-style core (user or kernel) and sequences every change of that mode. Each cycle it looks at the decode flags of the instruction that issues, the issuing PC and the two interrupt request lines. From these it decides whether a trap is entered, a return is performed, or nothing happens. When the mode changes it drives a next-PC override in the same cycle. It also updates the saved-PC, cause and status registers that the trap handler reads.

The mode is the state of a two-state machine, with states `MODE_USER` and `MODE_KERNEL`. Each cycle one event is chosen from `EV_NONE`, `EV_EXCEPT`, `EV_ECALL`, `EV_IRQ`, `EV_MRET` and `EV_SRET`, and that event selects the transition:

- `TRAP_ENTRY` runs from either state to `MODE_KERNEL` and is taken on `EV_EXCEPT`, `EV_ECALL` or `EV_IRQ`.
- `TRAP_RETURN` runs from `MODE_KERNEL` to `MODE_USER` and is taken on `EV_MRET` or `EV_SRET`.
- `HOLD` keeps the current state on `EV_NONE`.

A privileged instruction that issues in user mode is not executed. It is turned into an illegal-instruction trap instead, and `priv_fault` flags it.

Top module: `trap_mode_ctrl`

## Requirements
- R1: After reset, `mode` is 0 (user), `mepc_o` and `mcause_o` are 0, and `mstatus_o` is 0x88, meaning bit 3 (interrupt enable) and bit 7 (previous interrupt enable) are set.
- R2: `mode` reads 0 in user mode and 1 in kernel mode. Every trap entry leaves `mode` at 1.
- R3: An issuing instruction counts as privileged when `is_priv`, `is_mret` or `is_sret` is set. If it issues in user mode it does not execute. Instead `priv_fault` is 1, `redirect_pc` is `mtvec`, `mcause_o` becomes 2 and `mepc_o` becomes `pc`.
- R4: An issuing instruction with `is_illegal` set traps with cause 2 and `mepc_o` = `pc`, in either mode.
- R5: On any trap entry, `redirect_valid` is 1 and `redirect_pc` equals `mtvec` in the same cycle. On the next edge, bit 7 takes the old bit 3, bit 3 is cleared and `mode` becomes 1.
- R6: An issuing `is_ecall` traps with `mepc_o` = `pc` + 4. The cause is 8 when it issues in user mode and 11 when it issues in kernel mode.
- R7: An interrupt is taken only while bit 3 of `mstatus_o` is 1, with `mepc_o` = `pc`. `irq_ext` gives cause 0x8000000B and wins over `irq_timer`, which gives cause 0x80000007. While bit 3 is 0, the request lines change nothing.
- R8: Priority is: exception (R3/R4) first, then ecall, then interrupt, then return. The highest-ranked event present is the only one performed.
- R9: `is_mret` in kernel mode sets `redirect_pc` to `mepc_o`. Bit 3 takes bit 7, bit 7 is set, `mode` becomes 0, and `mepc_o` and `mcause_o` are unchanged.
- R10: `is_sret` in kernel mode sets `redirect_pc` to `sepc`. Bit 1 takes bit 5, bit 5 is set, and `mode` becomes 0.
- R11: When no event is selected, `redirect_valid` is 0 and the mode and all registers hold. Decode flags with `issue_valid` low are ignored.
- R12: All bits of `mstatus_o` other than 1, 3, 5 and 7 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | An instruction issues this cycle |
| is_priv | input | 1 | Issuing instruction needs kernel mode |
| is_ecall | input | 1 | Issuing instruction is an environment call |
| is_mret | input | 1 | Issuing instruction is a machine trap return |
| is_sret | input | 1 | Issuing instruction is a supervisor trap return |
| is_illegal | input | 1 | Issuing instruction failed decode |
| pc | input | XLEN | PC of the issuing instruction |
| irq_timer | input | 1 | Timer interrupt request |
| irq_ext | input | 1 | External device interrupt request |
| mtvec | input | XLEN | Trap vector base |
| sepc | input | XLEN | Supervisor return address |
| redirect_valid | output | 1 | Next-PC override is active this cycle |
| redirect_pc | output | XLEN | Next-PC override value |
| priv_fault | output | 1 | Privileged instruction issued in user mode |
| mode | output | 1 | Current mode, 0 user, 1 kernel |
| mepc_o | output | XLEN | Saved trap PC |
| mcause_o | output | XLEN | Trap cause |
| mstatus_o | output | XLEN | Status register |

## Verification
Traps are tried with a lone privileged flag, a lone `mret` and a lone `sret` in user mode. This separates a missing privilege check from a wrong redirect target. Environment calls are issued from both modes, which tells the mode-dependent cause apart and shows the PC + 4 offset. Interrupt requests arrive with bit 3 set and with it clear, and timer and external arrive alone and together. This exposes wrong gating and wrong ordering between the two interrupts. Several sources are also raised in the same cycle (illegal with ecall and interrupt, ecall with interrupt, illegal with mret) to pin down the priority order. Repeated trap/return pairs show that the previous-enable bits carry across, with bit 3 restored by mret and bit 1 restored by sret.

// File: rtl/trap_mode_pkg.sv
package trap_mode_pkg;

    typedef enum logic {
        MODE_USER   = 1'b0,
        MODE_KERNEL = 1'b1
    } mode_e;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_EXCEPT,
        EV_ECALL,
        EV_IRQ,
        EV_MRET,
        EV_SRET
    } event_e;

    localparam int SIE_BIT  = 1;
    localparam int MIE_BIT  = 3;
    localparam int SPIE_BIT = 5;
    localparam int MPIE_BIT = 7;

    localparam int CODE_ILLEGAL  = 2;
    localparam int CODE_ECALL_U  = 8;
    localparam int CODE_ECALL_K  = 11;
    localparam int CODE_IRQ_TMR  = 7;
    localparam int CODE_IRQ_EXT  = 11;

endpackage

// File: rtl/trap_event_arb.sv
module trap_event_arb
    import trap_mode_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic              issue_valid,
    input  logic              is_priv,
    input  logic              is_ecall,
    input  logic              is_mret,
    input  logic              is_sret,
    input  logic              is_illegal,
    input  mode_e             cur_mode,
    input  logic              irq_en,
    input  logic              irq_timer,
    input  logic              irq_ext,
    output event_e            ev,
    output logic [XLEN-1:0]   cause,
    output logic              priv_fault
);

    localparam logic [XLEN-1:0] IRQ_FLAG = {1'b1, {(XLEN-1){1'b0}}};

    logic needs_kernel;
    logic excpt;
    logic irq_any;

    always_comb begin
        needs_kernel = is_priv | is_mret | is_sret;
        priv_fault   = issue_valid & needs_kernel & (cur_mode == MODE_USER);
        excpt        = priv_fault | (issue_valid & is_illegal);
        irq_any      = irq_en & (irq_timer | irq_ext);
    end

    always_comb begin
        ev    = EV_NONE;
        cause = '0;
        if (excpt) begin
            ev    = EV_EXCEPT;
            cause = XLEN'(CODE_ILLEGAL);
        end else if (issue_valid && is_ecall) begin
            ev    = EV_ECALL;
            cause = (cur_mode == MODE_KERNEL) ? XLEN'(CODE_ECALL_K) : XLEN'(CODE_ECALL_U);
        end else if (irq_any) begin
            ev    = EV_IRQ;
            cause = IRQ_FLAG | (irq_ext ? XLEN'(CODE_IRQ_EXT) : XLEN'(CODE_IRQ_TMR));
        end else if (issue_valid && is_mret) begin
            ev = EV_MRET;
        end else if (issue_valid && is_sret) begin
            ev = EV_SRET;
        end
    end

endmodule

// File: rtl/trap_status_regs.sv
module trap_status_regs
    import trap_mode_pkg::*;
#(
    parameter int   XLEN      = 32,
    parameter logic RESET_MIE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  event_e            ev,
    input  logic [XLEN-1:0]   cause,
    input  logic [XLEN-1:0]   pc,
    output logic [XLEN-1:0]   mepc,
    output logic [XLEN-1:0]   mcause,
    output logic [XLEN-1:0]   mstatus
);

    localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);

    logic mie_q, mpie_q, sie_q, spie_q;
    logic is_entry;

    always_comb begin
        is_entry = (ev == EV_EXCEPT) || (ev == EV_ECALL) || (ev == EV_IRQ);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mepc   <= '0;
            mcause <= '0;
            mie_q  <= RESET_MIE;
            mpie_q <= RESET_MIE;
            sie_q  <= 1'b0;
            spie_q <= 1'b0;
        end else begin
            unique case (ev)
                EV_EXCEPT, EV_IRQ, EV_ECALL: begin
                    mepc   <= (ev == EV_ECALL) ? pc + INSN_BYTES : pc;
                    mcause <= cause;
                    mpie_q <= mie_q;
                    mie_q  <= 1'b0;
                end
                EV_MRET: begin
                    mie_q  <= mpie_q;
                    mpie_q <= 1'b1;
                end
                EV_SRET: begin
                    sie_q  <= spie_q;
                    spie_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        mstatus           = '0;
        mstatus[SIE_BIT]  = sie_q;
        mstatus[MIE_BIT]  = mie_q;
        mstatus[SPIE_BIT] = spie_q;
        mstatus[MPIE_BIT] = mpie_q;
    end

    assert_entry_clears_mie_R5: assert property (@(posedge clk) disable iff (!rst_n)
        is_entry |=> (mstatus[MIE_BIT] == 1'b0) && (mstatus[MPIE_BIT] == $past(mstatus[MIE_BIT])));

    assert_ecall_mepc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_ECALL) |=> (mepc == $past(pc) + INSN_BYTES));

    assert_mret_keeps_mepc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_MRET) |=> $stable(mepc) && $stable(mcause) && mstatus[MPIE_BIT]);

    assert_sret_sets_spie_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_SRET) |=> mstatus[SPIE_BIT] && (mstatus[SIE_BIT] == $past(mstatus[SPIE_BIT])));

    assert_status_unused_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(mstatus) == $countones({mstatus[MPIE_BIT], mstatus[SPIE_BIT],
                                            mstatus[MIE_BIT], mstatus[SIE_BIT]}));

endmodule

// File: rtl/trap_mode_ctrl.sv
module trap_mode_ctrl
    import trap_mode_pkg::*;
#(
    parameter int   XLEN      = 32,
    parameter logic RESET_MIE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    input  logic              is_priv,
    input  logic              is_ecall,
    input  logic              is_mret,
    input  logic              is_sret,
    input  logic              is_illegal,
    input  logic [XLEN-1:0]   pc,
    input  logic              irq_timer,
    input  logic              irq_ext,
    input  logic [XLEN-1:0]   mtvec,
    input  logic [XLEN-1:0]   sepc,
    output logic              redirect_valid,
    output logic [XLEN-1:0]   redirect_pc,
    output logic              priv_fault,
    output logic              mode,
    output logic [XLEN-1:0]   mepc_o,
    output logic [XLEN-1:0]   mcause_o,
    output logic [XLEN-1:0]   mstatus_o
);

    mode_e            state_q, state_d;
    event_e           ev;
    logic [XLEN-1:0]  cause;

    trap_event_arb #(.XLEN(XLEN)) u_arb (
        .issue_valid (issue_valid),
        .is_priv     (is_priv),
        .is_ecall    (is_ecall),
        .is_mret     (is_mret),
        .is_sret     (is_sret),
        .is_illegal  (is_illegal),
        .cur_mode    (state_q),
        .irq_en      (mstatus_o[MIE_BIT]),
        .irq_timer   (irq_timer),
        .irq_ext     (irq_ext),
        .ev          (ev),
        .cause       (cause),
        .priv_fault  (priv_fault)
    );

    trap_status_regs #(.XLEN(XLEN), .RESET_MIE(RESET_MIE)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev      (ev),
        .cause   (cause),
        .pc      (pc),
        .mepc    (mepc_o),
        .mcause  (mcause_o),
        .mstatus (mstatus_o)
    );

    // next-state: TRAP_ENTRY, TRAP_RETURN, HOLD
    always_comb begin
        state_d = state_q;
        unique case (ev)
            EV_EXCEPT, EV_ECALL, EV_IRQ: state_d = MODE_KERNEL;
            EV_MRET, EV_SRET:            state_d = MODE_USER;
            default:                     state_d = state_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MODE_USER;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        redirect_valid = 1'b0;
        redirect_pc    = '0;
        unique case (ev)
            EV_EXCEPT, EV_ECALL, EV_IRQ: begin
                redirect_valid = 1'b1;
                redirect_pc    = mtvec;
            end
            EV_MRET: begin
                redirect_valid = 1'b1;
                redirect_pc    = mepc_o;
            end
            EV_SRET: begin
                redirect_valid = 1'b1;
                redirect_pc    = sepc;
            end
            default: ;
        endcase
        mode = state_q;
    end

    assert_priv_fault_vectors_R3: assert property (@(posedge clk) disable iff (!rst_n)
        priv_fault |-> redirect_valid && (redirect_pc == mtvec) && (mode == 1'b0));

    assert_entry_goes_kernel_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_valid && redirect_pc == mtvec && ev != EV_MRET && ev != EV_SRET) |=> (mode == 1'b1));

    assert_irq_needs_mie_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_IRQ) |-> mstatus_o[MIE_BIT]);

    assert_return_from_kernel_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_MRET || ev == EV_SRET) |-> (mode == 1'b1) ##1 (mode == 1'b0));

    assert_hold_when_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !redirect_valid |=> $stable(mode) && $stable(mepc_o) && $stable(mcause_o));

endmodule

// File: tb/trap_mode_ctrl_tb.sv
module trap_mode_ctrl_tb;

    localparam int XLEN = 32;
    localparam logic [31:0] VEC = 32'h8000_0040;

    logic clk = 1'b0;
    logic rst_n;
    logic issue_valid, is_priv, is_ecall, is_mret, is_sret, is_illegal;
    logic [31:0] pc, mtvec, sepc;
    logic irq_timer, irq_ext;
    logic redirect_valid, priv_fault, mode;
    logic [31:0] redirect_pc, mepc_o, mcause_o, mstatus_o;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    trap_mode_ctrl #(.XLEN(XLEN)) u_dut (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .is_priv(is_priv),
        .is_ecall(is_ecall), .is_mret(is_mret), .is_sret(is_sret), .is_illegal(is_illegal),
        .pc(pc), .irq_timer(irq_timer), .irq_ext(irq_ext), .mtvec(mtvec), .sepc(sepc),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc), .priv_fault(priv_fault),
        .mode(mode), .mepc_o(mepc_o), .mcause_o(mcause_o), .mstatus_o(mstatus_o)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic clear_in();
        issue_valid = 0; is_priv = 0; is_ecall = 0; is_mret = 0; is_sret = 0;
        is_illegal = 0; irq_timer = 0; irq_ext = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        clear_in();
        rst_n = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1;
    endtask

    // drive at negedge, check same-cycle outputs, then let the edge pass
    task automatic drive(input logic iv, input logic pr, input logic ec, input logic mr,
                         input logic sr, input logic il, input logic it, input logic ie,
                         input logic [31:0] p);
        @(negedge clk);
        issue_valid = iv; is_priv = pr; is_ecall = ec; is_mret = mr;
        is_sret = sr; is_illegal = il; irq_timer = it; irq_ext = ie; pc = p;
        #1;
    endtask

    task automatic commit();
        @(posedge clk);
        #1;
        clear_in();
        #0.5;
    endtask

    task automatic t_reset_state();
        do_reset();
        #1;
        chk("R1", "mode", {31'b0, mode}, 32'd0);
        chk("R1", "mepc", mepc_o, 32'd0);
        chk("R1", "mcause", mcause_o, 32'd0);
        chk("R1", "mstatus", mstatus_o, 32'h88);
    endtask

    task automatic t_idle();
        do_reset();
        drive(0, 1, 1, 1, 1, 1, 0, 0, 32'h50);
        chk("R11", "redirect_valid idle", {31'b0, redirect_valid}, 32'd0);
        commit();
        chk("R11", "mode idle", {31'b0, mode}, 32'd0);
        chk("R11", "mcause idle", mcause_o, 32'd0);
        chk("R11", "mstatus idle", mstatus_o, 32'h88);
    endtask

    task automatic t_priv_user();
        do_reset();
        drive(1, 1, 0, 0, 0, 0, 0, 0, 32'h100);
        chk("R3", "priv_fault", {31'b0, priv_fault}, 32'd1);
        chk("R5", "redirect_valid", {31'b0, redirect_valid}, 32'd1);
        chk("R5", "redirect_pc", redirect_pc, VEC);
        commit();
        chk("R2", "mode kernel", {31'b0, mode}, 32'd1);
        chk("R3", "mcause", mcause_o, 32'd2);
        chk("R3", "mepc", mepc_o, 32'h100);
        chk("R5", "mstatus", mstatus_o, 32'h80);
        // kernel mode: the same flag now executes without a trap
        drive(1, 1, 0, 0, 0, 0, 0, 0, 32'h104);
        chk("R3", "no fault kernel", {31'b0, priv_fault}, 32'd0);
        chk("R3", "no redirect kernel", {31'b0, redirect_valid}, 32'd0);
        commit();
        // mret returns
        drive(1, 0, 0, 1, 0, 0, 0, 0, 32'h108);
        chk("R9", "mret redirect", redirect_pc, 32'h100);
        commit();
        chk("R9", "mode user", {31'b0, mode}, 32'd0);
        chk("R9", "mstatus", mstatus_o, 32'h88);
        chk("R9", "mepc kept", mepc_o, 32'h100);
        chk("R9", "mcause kept", mcause_o, 32'd2);
        // mret in user: fault, not a return
        drive(1, 0, 0, 1, 0, 0, 0, 0, 32'h200);
        chk("R3", "mret user fault", {31'b0, priv_fault}, 32'd1);
        chk("R3", "mret user vec", redirect_pc, VEC);
        commit();
        chk("R3", "mret user mepc", mepc_o, 32'h200);
        chk("R3", "mret user mode", {31'b0, mode}, 32'd1);
        // sret in user also faults
        do_reset();
        drive(1, 0, 0, 0, 1, 0, 0, 0, 32'h240);
        chk("R3", "sret user fault", {31'b0, priv_fault}, 32'd1);
        commit();
        chk("R3", "sret user cause", mcause_o, 32'd2);
        chk("R3", "sret user status", mstatus_o, 32'h80);
    endtask

    task automatic t_ecall_modes();
        do_reset();
        drive(1, 0, 1, 0, 0, 0, 0, 0, 32'h200);
        chk("R6", "ecall vec", redirect_pc, VEC);
        commit();
        chk("R6", "ecall user cause", mcause_o, 32'd8);
        chk("R6", "ecall user mepc", mepc_o, 32'h204);
        chk("R2", "ecall mode", {31'b0, mode}, 32'd1);
        drive(1, 0, 1, 0, 0, 0, 0, 0, 32'h300);
        commit();
        chk("R6", "ecall kernel cause", mcause_o, 32'd11);
        chk("R6", "ecall kernel mepc", mepc_o, 32'h304);
        chk("R5", "ecall kernel mstatus", mstatus_o, 32'h00);
        drive(1, 0, 0, 1, 0, 0, 0, 0, 32'h308);
        commit();
        chk("R9", "mret mie from mpie 0", mstatus_o, 32'h80);
        // illegal in user mode and in kernel mode
        drive(1, 0, 0, 0, 0, 1, 0, 0, 32'h400);
        commit();
        chk("R4", "illegal user cause", mcause_o, 32'd2);
        chk("R4", "illegal user mepc", mepc_o, 32'h400);
        drive(1, 0, 0, 0, 0, 1, 0, 0, 32'h410);
        chk("R4", "illegal kernel redirect", redirect_pc, VEC);
        commit();
        chk("R4", "illegal kernel mepc", mepc_o, 32'h410);
        chk("R4", "illegal kernel mode", {31'b0, mode}, 32'd1);
    endtask

    task automatic t_irq();
        do_reset();
        drive(0, 0, 0, 0, 0, 0, 1, 1, 32'h500);
        chk("R7", "irq redirect", {31'b0, redirect_valid}, 32'd1);
        commit();
        chk("R7", "ext wins cause", mcause_o, 32'h8000_000B);
        chk("R7", "irq mepc", mepc_o, 32'h500);
        chk("R5", "irq mstatus", mstatus_o, 32'h80);
        drive(0, 0, 0, 0, 0, 0, 1, 0, 32'h510);
        chk("R7", "masked no redirect", {31'b0, redirect_valid}, 32'd0);
        commit();
        chk("R7", "masked cause kept", mcause_o, 32'h8000_000B);
        chk("R7", "masked mepc kept", mepc_o, 32'h500);
        drive(1, 0, 0, 1, 0, 0, 0, 0, 32'h520);
        commit();
        chk("R9", "mret reenables", mstatus_o, 32'h88);
        drive(0, 0, 0, 0, 0, 0, 1, 0, 32'h530);
        commit();
        chk("R7", "timer cause", mcause_o, 32'h8000_0007);
        chk("R7", "timer mepc", mepc_o, 32'h530);
    endtask

    task automatic t_priority();
        do_reset();
        drive(1, 0, 1, 0, 0, 1, 1, 0, 32'h600);
        commit();
        chk("R8", "illegal over ecall/irq", mcause_o, 32'd2);
        chk("R8", "illegal mepc", mepc_o, 32'h600);
        do_reset();
        drive(1, 0, 1, 0, 0, 0, 0, 1, 32'h700);
        commit();
        chk("R8", "ecall over irq", mcause_o, 32'd8);
        chk("R8", "ecall over irq mepc", mepc_o, 32'h704);
        drive(1, 0, 0, 1, 0, 1, 0, 0, 32'h710);
        chk("R8", "illegal over mret target", redirect_pc, VEC);
        commit();
        chk("R8", "illegal over mret mode", {31'b0, mode}, 32'd1);
        chk("R8", "illegal over mret cause", mcause_o, 32'd2);
    endtask

    task automatic t_sret();
        do_reset();
        sepc = 32'h900;
        drive(1, 0, 1, 0, 0, 0, 0, 0, 32'h880);
        commit();
        drive(1, 0, 0, 0, 1, 0, 0, 0, 32'h884);
        chk("R10", "sret redirect", redirect_pc, 32'h900);
        commit();
        chk("R10", "sret mode", {31'b0, mode}, 32'd0);
        chk("R10", "sret status 1", mstatus_o, 32'hA0);
        drive(1, 0, 1, 0, 0, 0, 0, 0, 32'h910);
        commit();
        chk("R12", "status after ecall", mstatus_o, 32'h20);
        drive(1, 0, 0, 0, 1, 0, 0, 0, 32'h914);
        commit();
        chk("R10", "sret status 2", mstatus_o, 32'h22);
        chk("R10", "sret mode 2", {31'b0, mode}, 32'd0);
    endtask

    initial begin
        #800000;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 0;
        pc = 0;
        mtvec = VEC;
        sepc = 0;
        clear_in();
        t_reset_state();
        t_idle();
        t_priv_user();
        t_ecall_modes();
        t_irq();
        t_priority();
        t_sret();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule